// File: doc/BRIEF.md
# Pulse Period Car Identifier

This block tells which car passed a lane sensor. Each car emits sensor pulses at its own characteristic period, so the block timestamps every sensor edge against a free-running timer shared by the whole system. It compares each timestamp with the one taken at the edge before, and sorts the resulting interval into one of four fixed period windows. A match yields a car number from 1 to 4, and that number stays latched until software-side logic clears it. A lane uses one instance. A second lane uses a second instance fed from the same timer.

The shared timer counts up and wraps to zero. Its wrap strobe loads the stored timestamp with the timer's top value, so the first edge after a wrap never produces a measurement. Intervals that fall outside every window are discarded. So are edges whose timestamp is not above the stored one. Debouncing of the sensor happens upstream.

Top module: `car_id_decode`

## Requirements
- R1: After reset `car_id` is 0 and the stored timestamp is 0, so the first edge at timer value T is measured as an interval of T ticks.
- R2: An interval strictly greater than 54 and strictly less than 74 ticks decodes to ID 1; exactly 54 or 74 gives no ID.
- R3: An interval strictly between 118 and 138 ticks decodes to ID 2.
- R4: An interval strictly between 186 and 206 ticks decodes to ID 3.
- R5: An interval strictly between 246 and 266 ticks decodes to ID 4; exactly 266 gives no ID.
- R6: An edge is measured only when the stored timestamp is strictly less than the new timer value. The new value is stored on every edge, measured or not.
- R7: An interval outside all four windows leaves `car_id` unchanged.
- R8: Once `car_id` is nonzero, later edges do not change it until it is cleared.
- R9: `id_clr` forces `car_id` to 0 on the next cycle and takes priority over a decode in the same cycle. The edge in that cycle is still stored.
- R10: `tmr_wrap` loads the stored timestamp with `TIMER_TOP`. An edge in the same cycle is measured against the old stored value.
- R11: `car_id` is registered: a decode shows on the cycle after the clock edge that sampled `sense_edge`, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_val | input | TIMER_W | Current value of the shared free-running timer |
| tmr_wrap | input | 1 | One-cycle strobe when the timer wraps |
| sense_edge | input | 1 | One-cycle strobe for a sensor edge |
| id_clr | input | 1 | Returns the latched ID to 0 |
| car_id | output | ID_W | Latched car number, 0 when unknown |

## Verification
The bench goes after both ends of every window. A design using inclusive comparisons would report a car at exactly 54 or 266 ticks. It replays an edge whose timestamp is lower than, or equal to, the stored one. A design comparing with less-or-equal would measure a zero interval there. A design that skipped the store on an unmeasured edge would then misdecode the following edge. It strobes the wrap both alone and together with an edge. A design that ignored the wrap would decode the first edge after it. It also asserts a clear in the same cycle as a decoding edge, which a design giving the decode priority would fail.

// File: rtl/car_id_pkg.sv
package car_id_pkg;

   // open-interval membership test, widened so any timer width fits
   function automatic logic in_open_window(input logic [31:0] lo,
                                           input logic [31:0] hi,
                                           input logic [31:0] v);
      return (v > lo) && (v < hi);
   endfunction

endpackage

// File: rtl/cid_capture.sv
module cid_capture #(
   parameter int unsigned TIMER_W   = 16,
   parameter int unsigned TIMER_TOP = 4999
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [TIMER_W-1:0] tmr_val,
   input  logic               tmr_wrap,
   input  logic               sense_edge,
   output logic               meas_vld,
   output logic [TIMER_W-1:0] meas_ticks
);

   logic [TIMER_W-1:0] last_stamp;

   assign meas_vld   = sense_edge && (last_stamp < tmr_val);
   assign meas_ticks = tmr_val - last_stamp;

   always_ff @(posedge clk) begin
      if (!rst_n)
         last_stamp <= '0;
      else if (tmr_wrap)
         last_stamp <= TIMER_W'(TIMER_TOP);
      else if (sense_edge)
         last_stamp <= tmr_val;
   end

   assert_wrap_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_wrap |=> last_stamp == TIMER_W'(TIMER_TOP));

   assert_edge_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_edge && !tmr_wrap) |=> last_stamp == $past(tmr_val));

   assert_idle_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!sense_edge && !tmr_wrap) |=> $stable(last_stamp));

endmodule

// File: rtl/cid_classify.sv
module cid_classify
   import car_id_pkg::*;
#(
   parameter int unsigned TIMER_W = 16,
   parameter int unsigned ID_W    = 3,
   parameter int unsigned NUM_WIN = 4,
   parameter int unsigned WIN_LO [NUM_WIN] = '{54, 118, 186, 246},
   parameter int unsigned WIN_HI [NUM_WIN] = '{74, 138, 206, 266}
) (
   input  logic [TIMER_W-1:0] meas_ticks,
   output logic               hit_any,
   output logic [ID_W-1:0]    hit_id
);

   logic [NUM_WIN-1:0] hit;

   for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
      if (WIN_LO[g] >= WIN_HI[g]) begin : g_bad_order
         $error("window %0d: lower bound not below upper bound", g);
      end
      if (g > 0) begin : g_chk_sorted
         if (WIN_LO[g] < WIN_HI[g-1]) begin : g_overlap
            $error("window %0d overlaps its predecessor", g);
         end
      end
      assign hit[g] = in_open_window(32'(WIN_LO[g]), 32'(WIN_HI[g]),
                                     32'(meas_ticks));
   end

   always_comb begin
      hit_id = '0;
      for (int i = 0; i < NUM_WIN; i++)
         if (hit[i]) hit_id = ID_W'(i + 1);
   end

   assign hit_any = |hit;

   always_comb begin
      assert_one_window_R7: assert ($onehot0(hit));
   end

endmodule

// File: rtl/cid_latch.sv
module cid_latch #(
   parameter int unsigned ID_W    = 3,
   parameter int unsigned NUM_WIN = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            id_clr,
   input  logic            dec_vld,
   input  logic [ID_W-1:0] dec_id,
   output logic [ID_W-1:0] car_id
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         car_id <= '0;
      else if (id_clr)
         car_id <= '0;
      else if ((car_id == '0) && dec_vld)
         car_id <= dec_id;
   end

   assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      id_clr |=> car_id == '0);

   assert_hold_latched_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (car_id != '0 && !id_clr) |=> car_id == $past(car_id));

   assert_no_spurious_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (car_id == '0 && !dec_vld) |=> car_id == '0);

   assert_id_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      32'(car_id) <= NUM_WIN);

endmodule

// File: rtl/car_id_decode.sv
module car_id_decode #(
   parameter int unsigned TIMER_W   = 16,
   parameter int unsigned TIMER_TOP = 4999,
   parameter int unsigned NUM_WIN   = 4,
   parameter int unsigned ID_W      = 3,
   parameter int unsigned WIN_LO [NUM_WIN] = '{54, 118, 186, 246},
   parameter int unsigned WIN_HI [NUM_WIN] = '{74, 138, 206, 266}
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [TIMER_W-1:0] tmr_val,
   input  logic               tmr_wrap,
   input  logic               sense_edge,
   input  logic               id_clr,
   output logic [ID_W-1:0]    car_id
);

   localparam int unsigned ID_W_MIN = $clog2(NUM_WIN + 1);

   if (ID_W < ID_W_MIN) begin : g_bad_id_w
      $error("ID_W too narrow for NUM_WIN windows");
   end
   if (TIMER_W > 32 || TIMER_W < 2) begin : g_bad_timer_w
      $error("TIMER_W out of range");
   end
   if (TIMER_TOP >= (64'd1 << TIMER_W)) begin : g_bad_top
      $error("TIMER_TOP does not fit TIMER_W");
   end

   logic               meas_vld;
   logic [TIMER_W-1:0] meas_ticks;
   logic               hit_any;
   logic [ID_W-1:0]    hit_id;

   cid_capture #(
      .TIMER_W   (TIMER_W),
      .TIMER_TOP (TIMER_TOP)
   ) i_capture (
      .clk        (clk),
      .rst_n      (rst_n),
      .tmr_val    (tmr_val),
      .tmr_wrap   (tmr_wrap),
      .sense_edge (sense_edge),
      .meas_vld   (meas_vld),
      .meas_ticks (meas_ticks)
   );

   cid_classify #(
      .TIMER_W (TIMER_W),
      .ID_W    (ID_W),
      .NUM_WIN (NUM_WIN),
      .WIN_LO  (WIN_LO),
      .WIN_HI  (WIN_HI)
   ) i_classify (
      .meas_ticks (meas_ticks),
      .hit_any    (hit_any),
      .hit_id     (hit_id)
   );

   cid_latch #(
      .ID_W    (ID_W),
      .NUM_WIN (NUM_WIN)
   ) i_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .id_clr  (id_clr),
      .dec_vld (meas_vld && hit_any),
      .dec_id  (hit_id),
      .car_id  (car_id)
   );

endmodule

// File: tb/test_car_id_decode.sv
`timescale 1ns/1ps
module test_car_id_decode;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] tmr_val = '0;
   logic        tmr_wrap = 1'b0;
   logic        sense_edge = 1'b0;
   logic        id_clr = 1'b0;
   logic [2:0]  car_id;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   car_id_decode i_car_id_decode (
      .clk        (clk),
      .rst_n      (rst_n),
      .tmr_val    (tmr_val),
      .tmr_wrap   (tmr_wrap),
      .sense_edge (sense_edge),
      .id_clr     (id_clr),
      .car_id     (car_id)
   );

   task automatic check(input string req, input logic [2:0] exp);
      n_checks++;
      if (car_id !== exp) begin
         n_fail++;
         $display("FAIL %s: car_id=%0d expected %0d", req, car_id, exp);
      end
   endtask

   // edge at timer value t, optional wrap and clear in the same cycle
   task automatic edge_at(input int t, input bit wrap, input bit clr,
                          input string req, input logic [2:0] exp);
      @(negedge clk);
      tmr_val = 16'(t); sense_edge = 1'b1; tmr_wrap = wrap; id_clr = clr;
      @(negedge clk);
      sense_edge = 1'b0; tmr_wrap = 1'b0; id_clr = 1'b0;
      check(req, exp);
   endtask

   task automatic clear_id();
      @(negedge clk);
      id_clr = 1'b1;
      @(negedge clk);
      id_clr = 1'b0;
      check("R9", 3'd0);
   endtask

   task automatic wrap_only();
      @(negedge clk);
      tmr_wrap = 1'b1;
      @(negedge clk);
      tmr_wrap = 1'b0;
   endtask

   task automatic t_reset();
      check("R1", 3'd0);
      edge_at(60, 0, 0, "R1", 3'd1);
      clear_id();
   endtask

   task automatic t_window1();
      edge_at(114, 0, 0, "R2", 3'd0);   // exactly 54
      edge_at(188, 0, 0, "R2", 3'd0);   // exactly 74
      edge_at(243, 0, 0, "R2", 3'd1);   // 55
      clear_id();
   endtask

   task automatic t_window2();
      edge_at(361, 0, 0, "R3", 3'd0);   // exactly 118
      // registered output: not visible before the sampling edge
      @(negedge clk);
      tmr_val = 16'd480; sense_edge = 1'b1;
      #1 check("R11", 3'd0);
      @(negedge clk);
      sense_edge = 1'b0;
      check("R3", 3'd2);                // 119
      clear_id();
   endtask

   task automatic t_window3_4();
      edge_at(680, 0, 0, "R4", 3'd3);   // 200
      clear_id();
      edge_at(945, 0, 0, "R5", 3'd4);   // 265
      clear_id();
      edge_at(1211, 0, 0, "R5", 3'd0);  // exactly 266
   endtask

   task automatic t_gap_and_hold();
      edge_at(1311, 0, 0, "R7", 3'd0);  // 100, no window
      edge_at(1371, 0, 0, "R7", 3'd1);  // 60
      edge_at(1571, 0, 0, "R8", 3'd1);  // 200 would be ID 3
      clear_id();
   endtask

   task automatic t_order();
      edge_at(1000, 0, 0, "R6", 3'd0);  // below stored value
      edge_at(1060, 0, 0, "R6", 3'd1);  // proves 1000 was stored
      clear_id();
      edge_at(1060, 0, 0, "R6", 3'd0);  // equal, not measured
      edge_at(1120, 0, 0, "R6", 3'd1);
      clear_id();
   endtask

   task automatic t_wrap();
      wrap_only();
      edge_at(60, 0, 0, "R10", 3'd0);   // first edge after wrap ignored
      edge_at(120, 0, 0, "R10", 3'd1);
      clear_id();
      edge_at(250, 1, 0, "R10", 3'd2);  // 130 against old value
      clear_id();
      edge_at(310, 0, 0, "R10", 3'd0);  // stored value is top
      edge_at(370, 0, 0, "R10", 3'd1);
      clear_id();
   endtask

   task automatic t_clear_priority();
      edge_at(430, 0, 1, "R9", 3'd0);   // 60 with clear
      edge_at(490, 0, 0, "R9", 3'd1);   // 430 was stored
      clear_id();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_window1();
      t_window2();
      t_window3_4();
      t_gap_and_hold();
      t_order();
      t_wrap();
      t_clear_priority();
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not complete");
      end
      $display("End of test - %0d assertions evaluated, %0d failures",
               n_checks, n_fail);
      $finish;
   end

endmodule